// File: doc/BRIEF.md
# On-Chip Memory Configuration Decoder

This block steers every program-space and data-space access of a processor core to one of four on-chip RAM blocks, to a small window of peripheral registers, or to external memory. Three of the RAM blocks (block 0, block 1 and block 3, 512 words each) move between the program space and the data space according to a 2-bit mapping mode. The core loads this mode at run time. The fourth block (block 2, 32 words) is always in data space. Any address that no resident block or register claims goes to the external select, so code can always run from external program memory.

Each access port (program and data) presents a request and a word address. One clock edge later the block drives a registered select, one-hot over {block 0..3, register window, external}, and the word offset inside the chosen target. An on-chip target never waits. While an external access is in its select phase and the ready input is low, the block raises `stall`. It then holds both select sets and does not capture new requests, so the requester must keep its next request steady.

Top module: `memcfg_decoder`

Address map with default parameters (word addresses):
- Data space: registers 0x0000–0x0005; block 2 0x0060–0x007F; block 0 0x0200–0x03FF; block 1 0x0400–0x05FF; block 3 0x0600–0x07FF.
- Program space: block 0 0xF800–0xF9FF; block 1 0xFA00–0xFBFF; block 3 0xFC00–0xFDFF.

## Requirements
- R1: After synchronous reset, every select output and `stall` are low, both offsets are 0, and the mapping mode is 0.
- R2: A mode written with `cfg_we` high first applies to requests captured on the clock edge after the write edge. A request presented in the same cycle as the write is decoded with the previous mode.
- R3: Program-space residency by mode: mode 0 has no blocks, mode 1 has block 0, mode 2 has blocks 0 and 1, mode 3 has blocks 0, 1 and 3. Blocks that are not resident in program space are resident in data space.
- R4: Block 2 answers data addresses 0x0060–0x007F in every mode and never answers any program address.
- R5: Data addresses 0 to 5 raise `data_reg_sel` with offset equal to the address, and never a RAM or external select.
- R6: An address that no resident block or register claims raises the external select for its space. This includes an address inside the window of a block that currently sits in the other space.
- R7: Selects and offset for a request appear in the cycle after the edge that captures it. An accepted request yields exactly one select. An idle cycle yields none. The offset is the address minus the block base, and it is 0 for external or idle.
- R8: When neither captured access is external, `stall` is low whatever `ext_ready` is.
- R9: While a captured access is external and `ext_ready` is low, `stall` is high, all selects and offsets hold, and inputs are not captured. The held request is captured on the edge after `ext_ready` is high.
- R10: The program and data selects never name the same RAM block in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the mapping mode |
| cfg_val | input | 2 | Mapping mode to load |
| prog_req | input | 1 | Program-space access request |
| prog_addr | input | 16 | Program-space word address |
| data_req | input | 1 | Data-space access request |
| data_addr | input | 16 | Data-space word address |
| ext_ready | input | 1 | External memory ready |
| prog_blk_sel | output | 4 | Program select, bit i = RAM block i |
| prog_ext_sel | output | 1 | Program access goes external |
| prog_off | output | 9 | Word offset inside the selected program block |
| data_blk_sel | output | 4 | Data select, bit i = RAM block i |
| data_reg_sel | output | 1 | Data access hits the register window |
| data_ext_sel | output | 1 | Data access goes external |
| data_off | output | 9 | Word offset inside the selected data target |
| stall | output | 1 | Requester must hold; external access not ready |

## Verification
For every mapping mode, the bench sweeps the first and last words of each block window, both spaces at once, together with just-outside addresses (0x0006, 0x0080, 0x01FF, 0x0800, 0xF7FF). This separates a wrong residency step from an off-by-one window edge. A mode write made together with a request separates "next cycle" from "same cycle" timing. External accesses with ready held low for several cycles, including one with a new request waiting, tell holding apart from dropping or early capture. A run of on-chip accesses with ready low shows whether stall wrongly depends on ready alone.

// File: rtl/memcfg_pkg.sv
`timescale 1ns/1ps
package memcfg_pkg;

  localparam int NUM_BLK = 4;

  typedef enum logic [1:0] {
    MAP_ALL_DATA = 2'd0,
    MAP_B0_PROG  = 2'd1,
    MAP_B01_PROG = 2'd2,
    MAP_ALL_PROG = 2'd3
  } map_mode_e;

  // Block 0 leaves data space first, then block 1, then block 3; block 2 never moves.
  function automatic logic blk_in_prog(input int unsigned blk, input map_mode_e m);
    case (blk)
      0:       return m != MAP_ALL_DATA;
      1:       return (m == MAP_B01_PROG) || (m == MAP_ALL_PROG);
      3:       return m == MAP_ALL_PROG;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/memcfg_mode_reg.sv
`timescale 1ns/1ps
module memcfg_mode_reg
  import memcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic [1:0] val,
  output map_mode_e mode
);

  always_ff @(posedge clk) begin
    if (rst)     mode <= MAP_ALL_DATA;
    else if (we) mode <= map_mode_e'(val);
  end

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (mode == map_mode_e'($past(val))));

  assert_mode_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mode));

endmodule

// File: rtl/memcfg_space_dec.sv
`timescale 1ns/1ps
module memcfg_space_dec
  import memcfg_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            OFF_W     = 9,
  parameter bit            IS_DATA   = 1'b1,
  parameter int            BLK_WORDS = 512,
  parameter int            B2_WORDS  = 32,
  parameter int            REG_COUNT = 6,
  parameter logic [4*AW-1:0] BASES   = '0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  map_mode_e        mode,
  input  logic             req,
  input  logic [AW-1:0]    addr,
  output logic [NUM_BLK-1:0] blk_sel,
  output logic             reg_sel,
  output logic             ext_sel,
  output logic [OFF_W-1:0] off
);

  localparam int LIM_W = AW + 1;

  logic [NUM_BLK-1:0] hit;
  logic [OFF_W-1:0]   boff [NUM_BLK];
  logic               reg_hit;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    localparam int              SZ = (g == 2) ? B2_WORDS : BLK_WORDS;
    localparam logic [LIM_W-1:0] LO = {1'b0, BASES[g*AW +: AW]};
    localparam logic [LIM_W-1:0] HI = LO + LIM_W'(SZ);
    logic here;
    assign here    = IS_DATA ? !blk_in_prog(g, mode) : blk_in_prog(g, mode);
    assign hit[g]  = here && ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    assign boff[g] = OFF_W'(addr - BASES[g*AW +: AW]);
  end

  if (IS_DATA) begin : g_regwin
    assign reg_hit = addr < AW'(REG_COUNT);
  end else begin : g_noreg
    assign reg_hit = 1'b0;
  end

  logic [NUM_BLK-1:0] n_blk;
  logic               n_reg, n_ext;
  logic [OFF_W-1:0]   n_off;

  always_comb begin
    n_blk = '0;
    n_reg = 1'b0;
    n_ext = 1'b0;
    n_off = '0;
    if (req) begin
      if (reg_hit) begin
        n_reg = 1'b1;
        n_off = OFF_W'(addr);
      end else if (|hit) begin
        n_blk = hit;
        for (int i = 0; i < NUM_BLK; i++)
          if (hit[i]) n_off = boff[i];
      end else begin
        n_ext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_sel <= '0;
      reg_sel <= 1'b0;
      ext_sel <= 1'b0;
      off     <= '0;
    end else if (!hold) begin
      blk_sel <= n_blk;
      reg_sel <= n_reg;
      ext_sel <= n_ext;
      off     <= n_off;
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable({blk_sel, reg_sel, ext_sel, off}));

  assert_one_target_R7: assert property (@(posedge clk) disable iff (rst)
    (req && !hold) |=> ($countones({blk_sel, reg_sel, ext_sel}) == 1));

  assert_idle_none_R7: assert property (@(posedge clk) disable iff (rst)
    (!req && !hold) |=> ({blk_sel, reg_sel, ext_sel} == '0));

endmodule

// File: rtl/memcfg_wait.sv
`timescale 1ns/1ps
module memcfg_wait (
  input  logic prog_ext,
  input  logic data_ext,
  input  logic ext_ready,
  output logic stall
);

  always_comb stall = (prog_ext || data_ext) && !ext_ready;

endmodule

// File: rtl/memcfg_decoder.sv
`timescale 1ns/1ps
module memcfg_decoder
  import memcfg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_WORDS = 512,
  parameter int B2_WORDS  = 32,
  parameter int REG_COUNT = 6,
  parameter logic [4*AW-1:0] DATA_BASES = {16'h0600, 16'h0060, 16'h0400, 16'h0200},
  parameter logic [4*AW-1:0] PROG_BASES = {16'hFC00, 16'h0000, 16'hFA00, 16'hF800}
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_val,
  input  logic                         prog_req,
  input  logic [AW-1:0]                prog_addr,
  input  logic                         data_req,
  input  logic [AW-1:0]                data_addr,
  input  logic                         ext_ready,
  output logic [3:0]                   prog_blk_sel,
  output logic                         prog_ext_sel,
  output logic [$clog2(BLK_WORDS)-1:0] prog_off,
  output logic [3:0]                   data_blk_sel,
  output logic                         data_reg_sel,
  output logic                         data_ext_sel,
  output logic [$clog2(BLK_WORDS)-1:0] data_off,
  output logic                         stall
);

  localparam int OFF_W = $clog2(BLK_WORDS);

  map_mode_e mode;
  logic      prog_reg_sel;

  memcfg_mode_reg u_mode (
    .clk (clk), .rst (rst), .we (cfg_we), .val (cfg_val), .mode (mode)
  );

  memcfg_space_dec #(
    .AW (AW), .OFF_W (OFF_W), .IS_DATA (1'b0), .BLK_WORDS (BLK_WORDS),
    .B2_WORDS (B2_WORDS), .REG_COUNT (REG_COUNT), .BASES (PROG_BASES)
  ) u_prog (
    .clk (clk), .rst (rst), .hold (stall), .mode (mode),
    .req (prog_req), .addr (prog_addr),
    .blk_sel (prog_blk_sel), .reg_sel (prog_reg_sel),
    .ext_sel (prog_ext_sel), .off (prog_off)
  );

  memcfg_space_dec #(
    .AW (AW), .OFF_W (OFF_W), .IS_DATA (1'b1), .BLK_WORDS (BLK_WORDS),
    .B2_WORDS (B2_WORDS), .REG_COUNT (REG_COUNT), .BASES (DATA_BASES)
  ) u_data (
    .clk (clk), .rst (rst), .hold (stall), .mode (mode),
    .req (data_req), .addr (data_addr),
    .blk_sel (data_blk_sel), .reg_sel (data_reg_sel),
    .ext_sel (data_ext_sel), .off (data_off)
  );

  memcfg_wait u_wait (
    .prog_ext (prog_ext_sel), .data_ext (data_ext_sel),
    .ext_ready (ext_ready), .stall (stall)
  );

  assert_no_shared_blk_R10: assert property (@(posedge clk) disable iff (rst)
    (prog_blk_sel & data_blk_sel) == 4'b0000);

  assert_onchip_nowait_R8: assert property (@(posedge clk) disable iff (rst)
    (!prog_ext_sel && !data_ext_sel) |-> !stall);

  assert_prog_no_regs_R5: assert property (@(posedge clk) disable iff (rst)
    !prog_reg_sel);

endmodule

// File: tb/sim_memcfg_decoder.sv
`timescale 1ns/1ps
module sim_memcfg_decoder;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_val;
  logic        prog_req, data_req, ext_ready;
  logic [15:0] prog_addr, data_addr;
  logic [3:0]  prog_blk_sel, data_blk_sel;
  logic        prog_ext_sel, data_reg_sel, data_ext_sel, stall;
  logic [8:0]  prog_off, data_off;

  always #2.5 clk = ~clk;

  memcfg_decoder u0 (
    .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_val (cfg_val),
    .prog_req (prog_req), .prog_addr (prog_addr),
    .data_req (data_req), .data_addr (data_addr), .ext_ready (ext_ready),
    .prog_blk_sel (prog_blk_sel), .prog_ext_sel (prog_ext_sel), .prog_off (prog_off),
    .data_blk_sel (data_blk_sel), .data_reg_sel (data_reg_sel),
    .data_ext_sel (data_ext_sel), .data_off (data_off), .stall (stall)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  // target codes: 0..3 RAM block, 4 register window, 5 external, 6 none, 7 several
  int m_cfg, m_pc, m_po, m_dc, m_do;
  bit m_take, m_live;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void exp_map(input bit is_d, input int cfg, input int a,
                                  output int code, output int off);
    int dbase[4];
    int pbase[4];
    bit inprog[4];
    dbase = '{'h200, 'h400, 0, 'h600};
    pbase = '{'hF800, 'hFA00, 0, 'hFC00};
    inprog = '{cfg >= 1, cfg >= 2, 1'b0, cfg == 3};
    code = 5;
    off  = 0;
    if (is_d && a < 6) begin code = 4; off = a; return; end
    if (is_d && a >= 'h60 && a < 'h80) begin code = 2; off = a - 'h60; return; end
    foreach (dbase[k]) begin
      int base;
      if (k == 2) continue;
      base = is_d ? dbase[k] : pbase[k];
      if ((inprog[k] != is_d) && a >= base && a < base + 512) begin
        code = k;
        off  = a - base;
      end
    end
  endfunction

  function automatic int act_code(input logic [3:0] b, input logic r, input logic e);
    int n;
    n = $countones({b, r, e});
    if (n == 0) return 6;
    if (n > 1)  return 7;
    if (r)      return 4;
    if (e)      return 5;
    for (int i = 0; i < 4; i++) if (b[i]) return i;
    return 7;
  endfunction

  // behavioural reference, advanced on every edge, compared 1 ns later
  always @(posedge clk) begin
    bit st, exp_st;
    st = (m_pc == 5 || m_dc == 5) && !ext_ready;
    if (rst) begin
      m_cfg = 0; m_pc = 6; m_po = 0; m_dc = 6; m_do = 0; m_take = 0; m_live = 0;
    end else begin
      m_live = 1;
      if (!st) begin
        if (prog_req) exp_map(1'b0, m_cfg, int'(prog_addr), m_pc, m_po);
        else begin m_pc = 6; m_po = 0; end
        if (data_req) exp_map(1'b1, m_cfg, int'(data_addr), m_dc, m_do);
        else begin m_dc = 6; m_do = 0; end
        m_take = 1;
      end else m_take = 0;
      if (cfg_we) m_cfg = int'(cfg_val);
    end
    #1;
    if (m_live) begin
      exp_st = (m_pc == 5 || m_dc == 5) && !ext_ready;
      chk(cur_tag, "prog target", act_code(prog_blk_sel, 1'b0, prog_ext_sel), m_pc);
      chk(cur_tag, "prog offset (R7)", int'(prog_off), m_po);
      chk(cur_tag, "data target", act_code(data_blk_sel, data_reg_sel, data_ext_sel), m_dc);
      chk(cur_tag, "data offset (R7)", int'(data_off), m_do);
      chk(exp_st ? "R9" : "R8", "stall", int'(stall), int'(exp_st));
      chk("R10", "shared block", int'(|(prog_blk_sel & data_blk_sel)), 0);
    end
  end

  task automatic acc(input bit pr, input int pa, input bit dr, input int da, input int waits);
    @(negedge clk);
    prog_req = pr; prog_addr = 16'(pa); data_req = dr; data_addr = 16'(da); ext_ready = 1'b1;
    @(posedge clk); #2;
    while (!m_take) begin @(posedge clk); #2; end
    prog_req = 1'b0; data_req = 1'b0;
    if (waits > 0) begin
      ext_ready = 1'b0;
      repeat (waits) begin @(posedge clk); #2; end
      ext_ready = 1'b1;
    end
  endtask

  task automatic setcfg(input int v);
    @(negedge clk); cfg_we = 1'b1; cfg_val = 2'(v);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    #(5ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_val = 2'd0; prog_req = 1'b0; data_req = 1'b0;
    prog_addr = '0; data_addr = '0; ext_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "prog selects", int'({prog_blk_sel, prog_ext_sel}), 0);
    chk("R1", "data selects", int'({data_blk_sel, data_reg_sel, data_ext_sel}), 0);
    chk("R1", "offsets", int'(prog_off) + int'(data_off), 0);
    chk("R1", "stall", int'(stall), 0);
    rst = 1'b0;
    cur_tag = "R1";
    acc(1, 'hF800, 1, 'h200, 0);   // mode 0 after reset: B0 in data space

    for (int c = 0; c < 4; c++) begin
      setcfg(c);
      cur_tag = "R3";
      acc(1, 'hF800, 1, 'h200, 0);
      acc(1, 'hF9FF, 1, 'h3FF, 0);
      acc(1, 'hFA00, 1, 'h400, 0);
      acc(1, 'hFBFF, 1, 'h5FF, 0);
      acc(1, 'hFC00, 1, 'h600, 0);
      acc(1, 'hFDFF, 1, 'h7FF, 0);
      cur_tag = "R4";
      acc(1, 'h0060, 1, 'h60, 0);
      acc(1, 'h007F, 1, 'h7F, 0);
      acc(0, 0, 1, 'h80, 0);
      cur_tag = "R5";
      for (int r = 0; r < 7; r++) acc(0, 0, 1, r, 0);
      cur_tag = "R6";
      acc(1, 'h0100, 1, 'h1FF, 0);
      acc(1, 'hF7FF, 1, 'h800, 0);
      acc(1, 'hFE00, 1, 'h5F, 0);
    end

    // R2: mode write together with a request uses the old mode (3 -> 0)
    cur_tag = "R2";
    @(negedge clk);
    cfg_we = 1'b1; cfg_val = 2'd0;
    prog_req = 1'b1; prog_addr = 16'hFC00; data_req = 1'b1; data_addr = 16'h0600;
    @(posedge clk); #2;
    cfg_we = 1'b0; prog_req = 1'b0; data_req = 1'b0;
    acc(1, 'hFC00, 1, 'h600, 0);

    // R9: external waits, with and without a held request
    setcfg(3);
    cur_tag = "R9";
    acc(1, 'hFA00, 1, 'h900, 3);
    acc(1, 'h0040, 0, 0, 1);
    @(negedge clk);
    data_req = 1'b1; data_addr = 16'h1000;
    @(posedge clk); #2;
    ext_ready = 1'b0; data_addr = 16'h0061; prog_req = 1'b1; prog_addr = 16'hFC05;
    repeat (2) begin @(posedge clk); #2; end
    ext_ready = 1'b1;
    @(posedge clk); #2;
    data_req = 1'b0; prog_req = 1'b0;

    // R8: on-chip accesses never wait on ready
    setcfg(0);
    cur_tag = "R8";
    @(negedge clk); ext_ready = 1'b0;
    data_req = 1'b1; data_addr = 16'h0201;
    @(negedge clk); data_addr = 16'h0062;
    @(negedge clk); data_addr = 16'h0003;
    @(negedge clk); data_req = 1'b0;
    @(negedge clk); ext_ready = 1'b1;

    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule